// File: doc/BRIEF.md
# Dual-Bank Multiscaler with Tagged FIFO Copy

This block counts input pulses on a set of 48-bit channels that exist twice, as two banks. Exactly one bank is live at a time and accumulates hits, while the other holds still. A "next" request, either from the leading edge of an external pulse or from a one-cycle software command, exchanges the roles of the two banks. A copy engine then walks the bank that has just gone still and writes each channel into an output FIFO as a two-word record.

The first word of each record carries a tag and the second carries the low counter bits. Copying never clears a bank, so every bank keeps adding up over all the time slices in which it is live. A per-channel skip mask leaves channels out of the copy. A new mask is staged and only applied at the next accepted swap. Two user bits are captured at the external next edge and travel with that slice's records. A full FIFO halts acquisition until the clear command is issued. A single-cycle clear resets everything and requests a FIFO flush.

The copy engine has three named states. In IDLE it waits, and an accepted swap (transition START) moves it to HEAD with channel 0. In HEAD, a channel that is skipped advances the channel (SKIP), or ends the copy when it was the last channel (DONE). A channel that is not skipped writes the tag word and moves to TAIL (EMIT). TAIL writes the low word, then moves on to the next channel in HEAD (ADVANCE), or to IDLE after the last channel (DONE). From HEAD or TAIL the engine returns to IDLE when the FIFO is full or the acquisition stop is set (ABORT), or when clear is asserted (FLUSH).

Top module: `msc_dual_bank`

## Requirements
- R1: On each clock edge, every channel of the live bank whose `cnt_in` bit is high increases by one, counters being 48 bits wide. The other bank does not change. Counting is suspended while `acq_stop` or `fifo_full` is high.
- R2: A next request is either a rising edge on `ext_next` or `sw_next` high. It is accepted when `next_arm` is high, the copy engine is idle and the acquisition is not stopped. An accepted request makes the other bank live. Reset and clear make bank 0 live.
- R3: Neither a swap nor a copy clears a bank. A bank's value is the total of all cycles in which it was live since the last clear.
- R4: `copy_busy` rises one cycle after an accepted request and stays high until the cycle after the last write of the copy.
- R5: Channels are copied in ascending order, and each record is two writes in consecutive cycles. The first word has the copied bank in bit 29, the channel index (0-based) in bits 28..24, user bits 1..0 in bits 21..20 and counter bits 47..32 in bits 15..0. All its other bits are zero. The second word is counter bits 31..0.
- R6: When bit i of the skip mask is set, channel i (0-based) is left out, and its cycle passes with no write. `mask_we` stages `mask_in`. The staged value is applied only at the next accepted request, so a write during a copy does not change that copy.
- R7: The user bits are taken from `user_in` at the accepted rising edge of `ext_next`. A software request keeps the previously captured value.
- R8: A request that arrives with `next_arm` high while `copy_busy` is high is ignored and sets `overrun`, which then stays high until clear.
- R9: When `fifo_full` is seen high, `acq_stop` sets and stays high even after `fifo_full` drops. While it is high there are no writes, no counting and no swaps. A copy in progress ends at once.
- R10: `clear` high for one cycle zeroes both banks and the user bits, clears `overrun` and `acq_stop`, returns the copy engine to IDLE, and drives `fifo_flush` high in that cycle.
- R11: With `next_arm` low, requests of both kinds have no effect. They cause no swap, no write and no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_in | input | NCH | One count per cycle per high bit |
| next_arm | input | 1 | Enables acceptance of next requests |
| ext_next | input | 1 | External next pulse, rising edge is used |
| sw_next | input | 1 | Software next command, one cycle |
| user_in | input | 2 | User bits captured at the external next edge |
| mask_in | input | NCH | Skip mask value to stage |
| mask_we | input | 1 | Stage `mask_in` |
| clear | input | 1 | Synchronous clear of banks, latches and engine |
| fifo_full | input | 1 | FIFO full flag |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 32 | FIFO write data |
| fifo_flush | output | 1 | FIFO flush request |
| copy_busy | output | 1 | Copy in progress |
| overrun | output | 1 | Sticky: request arrived during a copy |
| acq_stop | output | 1 | Sticky: acquisition halted by a full FIFO |

## Verification
A wrong live-bank selector shows up in the very next copy, as records that carry the wrong bank bit or counts that belong to the other bank. A lost accumulation shows up as a value that is smaller than the running total kept in the bench. A corrupt channel index or a stale skip mask shows up in the record count and in the tag field during the same copy, two cycles per channel after the request. Sticky flags that fail to hold, or fail to clear, can be read directly on the status ports in the cycle after the event that should set or clear them.

// File: rtl/msc_pkg.sv
package msc_pkg;
    typedef enum logic [1:0] {
        CP_IDLE = 2'd0,
        CP_HEAD = 2'd1,
        CP_TAIL = 2'd2
    } cp_state_t;

    localparam int TAG_BANK_BIT = 29;
    localparam int TAG_CH_LSB   = 24;
    localparam int TAG_USER_LSB = 20;
endpackage

// File: rtl/msc_bank_pair.sv
module msc_bank_pair #(
    parameter int NCH = 4,
    parameter int CW  = 48,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           cnt_en,
    input  logic           live,
    input  logic [NCH-1:0] cnt_in,
    input  logic [CHW-1:0] rd_ch,
    output logic [CW-1:0]  rd_val
);
    logic [CW-1:0] ctr [2][NCH];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ctr[b][c] <= '0;
                end else if (clr) begin
                    ctr[b][c] <= '0;
                end else if (cnt_en && (live == b[0]) && cnt_in[c]) begin
                    ctr[b][c] <= ctr[b][c] + 1'b1;
                end
            end
        end
    end

    assign rd_val = ctr[~live][rd_ch];
endmodule

// File: rtl/msc_copy_fsm.sv
module msc_copy_fsm
    import msc_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           start,
    input  logic           halt,
    input  logic [NCH-1:0] skip,
    output logic           busy,
    output logic           wr,
    output logic           head,
    output logic [CHW-1:0] ch
);
    localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

    cp_state_t st, st_nx;
    logic [CHW-1:0] ch_nx;
    logic is_last;

    assign is_last = (ch == LAST);

    always_comb begin
        st_nx = st;
        ch_nx = ch;
        unique case (st)
            CP_IDLE: begin
                if (start) begin
                    st_nx = CP_HEAD;
                    ch_nx = '0;
                end
            end
            CP_HEAD: begin
                if (halt) begin
                    st_nx = CP_IDLE;
                end else if (!skip[ch]) begin
                    st_nx = CP_TAIL;
                end else if (is_last) begin
                    st_nx = CP_IDLE;
                end else begin
                    ch_nx = ch + 1'b1;
                end
            end
            CP_TAIL: begin
                if (halt || is_last) begin
                    st_nx = CP_IDLE;
                end else begin
                    st_nx = CP_HEAD;
                    ch_nx = ch + 1'b1;
                end
            end
            default: st_nx = CP_IDLE;
        endcase
        if (clr) begin
            st_nx = CP_IDLE;
            ch_nx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= CP_IDLE;
            ch <= '0;
        end else begin
            st <= st_nx;
            ch <= ch_nx;
        end
    end

    always_comb begin
        busy = (st != CP_IDLE);
        head = (st == CP_HEAD);
        wr   = 1'b0;
        unique case (st)
            CP_IDLE: wr = 1'b0;
            CP_HEAD: wr = !halt && !skip[ch];
            CP_TAIL: wr = !halt;
            default: wr = 1'b0;
        endcase
    end
endmodule

// File: rtl/msc_dual_bank.sv
module msc_dual_bank
    import msc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 48,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cnt_in,
    input  logic           next_arm,
    input  logic           ext_next,
    input  logic           sw_next,
    input  logic [1:0]     user_in,
    input  logic [NCH-1:0] mask_in,
    input  logic           mask_we,
    input  logic           clear,
    input  logic           fifo_full,
    output logic           fifo_wr,
    output logic [31:0]    fifo_data,
    output logic           fifo_flush,
    output logic           copy_busy,
    output logic           overrun,
    output logic           acq_stop
);
    logic           ext_d, live, cp_bank, stop_lat, ovr_q;
    logic [1:0]     user_q;
    logic [NCH-1:0] mask_stage, mask_run;
    logic           ext_rise, req, take, halt, head;
    logic [CHW-1:0] ch;
    logic [CW-1:0]  val;

    assign ext_rise = ext_next && !ext_d;
    assign req      = ext_rise || sw_next;
    assign halt     = stop_lat || fifo_full;
    assign take     = req && next_arm && !copy_busy && !halt && !clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_d      <= 1'b0;
            live       <= 1'b0;
            cp_bank    <= 1'b0;
            stop_lat   <= 1'b0;
            ovr_q      <= 1'b0;
            user_q     <= '0;
            mask_stage <= '0;
            mask_run   <= '0;
        end else begin
            ext_d <= ext_next;
            if (mask_we) mask_stage <= mask_in;
            if (clear) begin
                live     <= 1'b0;
                cp_bank  <= 1'b0;
                stop_lat <= 1'b0;
                ovr_q    <= 1'b0;
                user_q   <= '0;
            end else begin
                if (fifo_full) stop_lat <= 1'b1;
                if (req && next_arm && copy_busy) ovr_q <= 1'b1;
                if (take) begin
                    live     <= ~live;
                    cp_bank  <= live;
                    mask_run <= mask_stage;
                    if (ext_rise) user_q <= user_in;
                end
            end
        end
    end

    msc_bank_pair #(.NCH(NCH), .CW(CW)) u_banks (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clear),
        .cnt_en (!halt),
        .live   (live),
        .cnt_in (cnt_in),
        .rd_ch  (ch),
        .rd_val (val)
    );

    msc_copy_fsm #(.NCH(NCH)) u_copy (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .start (take),
        .halt  (halt),
        .skip  (mask_run),
        .busy  (copy_busy),
        .wr    (fifo_wr),
        .head  (head),
        .ch    (ch)
    );

    always_comb begin
        fifo_data = '0;
        if (head) begin
            fifo_data[TAG_BANK_BIT]                = cp_bank;
            fifo_data[TAG_CH_LSB +: 5]             = 5'(ch);
            fifo_data[TAG_USER_LSB +: 2]           = user_q;
            fifo_data[15:0]                        = 16'(val[CW-1:32]);
        end else begin
            fifo_data = val[31:0];
        end
    end

    assign fifo_flush = clear;
    assign overrun    = ovr_q;
    assign acq_stop   = stop_lat;
endmodule

// File: rtl/msc_dual_bank_chk.sv
module msc_dual_bank_chk (
    input logic clk,
    input logic rst_n,
    input logic clear,
    input logic next_arm,
    input logic fifo_full,
    input logic fifo_wr,
    input logic copy_busy,
    input logic overrun,
    input logic acq_stop
);
    assert_write_in_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> copy_busy);

    assert_no_write_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full || acq_stop) |-> !fifo_wr);

    assert_stop_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_stop && !clear) |=> acq_stop);

    assert_full_sets_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !clear) |=> acq_stop);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clear) |=> overrun);

    assert_clear_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!copy_busy && !overrun && !acq_stop));

    assert_start_needs_arm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(copy_busy) |-> $past(next_arm));
endmodule

bind msc_dual_bank msc_dual_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .next_arm  (next_arm),
    .fifo_full (fifo_full),
    .fifo_wr   (fifo_wr),
    .copy_busy (copy_busy),
    .overrun   (overrun),
    .acq_stop  (acq_stop)
);

// File: tb/sim_msc_dual_bank.sv
`timescale 1ns/1ps
module sim_msc_dual_bank;
    localparam int NCH = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NCH-1:0] cnt_in = '0, mask_in = '0;
    logic next_arm = 1'b0, ext_next = 1'b0, sw_next = 1'b0, mask_we = 1'b0;
    logic clear = 1'b0, fifo_full = 1'b0;
    logic [1:0] user_in = '0;
    logic fifo_wr, fifo_flush, copy_busy, overrun, acq_stop;
    logic [31:0] fifo_data;

    always #2 clk = ~clk;

    msc_dual_bank #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .next_arm(next_arm),
        .ext_next(ext_next), .sw_next(sw_next), .user_in(user_in),
        .mask_in(mask_in), .mask_we(mask_we), .clear(clear),
        .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .fifo_flush(fifo_flush), .copy_busy(copy_busy), .overrun(overrun),
        .acq_stop(acq_stop)
    );

    int n_cmp = 0, n_bad = 0;
    longint mdl [2][NCH];
    int live_m = 0, user_m = 0;
    logic [31:0] cap [64];
    int ncap = 0, nbusy = 0;
    bit busy_end = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic count(input int k0, input int k1, input int k2, input int k3);
        int k [NCH];
        k[0] = k0; k[1] = k1; k[2] = k2; k[3] = k3;
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < NCH; i++) cnt_in[i] = (c < k[i]);
            @(negedge clk);
        end
        cnt_in = '0;
        if (!acq_stop)
            for (int i = 0; i < NCH; i++) mdl[live_m][i] += k[i];
    endtask

    // mode 0 plain, 1 second request during copy, 2 mask write during copy
    task automatic fire(input bit use_ext, input int mode);
        ncap = 0; nbusy = 0;
        if (use_ext) ext_next = 1'b1; else sw_next = 1'b1;
        @(negedge clk);
        ext_next = 1'b0; sw_next = 1'b0;
        for (int i = 0; i < 2*NCH + 6; i++) begin
            mask_we = 1'b0; sw_next = 1'b0;
            if (mode == 1 && i == 2) sw_next = 1'b1;
            if (mode == 2 && i == 1) begin mask_in = '0; mask_we = 1'b1; end
            if (copy_busy) nbusy++;
            if (fifo_wr) begin cap[ncap] = fifo_data; ncap++; end
            @(negedge clk);
        end
        mask_we = 1'b0; sw_next = 1'b0;
        busy_end = copy_busy;
    endtask

    task automatic check_copy(input string req, input int bank, input int mask);
        int w = 0;
        for (int i = 0; i < NCH; i++) begin
            if (!mask[i]) begin
                logic [31:0] h = (32'(bank) << 29) | (32'(i) << 24) | (32'(user_m) << 20)
                                 | 32'((mdl[bank][i] >> 32) & 64'hFFFF);
                chk(cap[w] == h, {req, " head word"}, cap[w], h);
                chk(cap[w+1] == mdl[bank][i][31:0], {req, " low word"}, cap[w+1], mdl[bank][i][31:0]);
                w += 2;
            end
        end
        chk(ncap == w, {req, " word count"}, ncap, w);
        chk(busy_end == 1'b0, "R4 busy ends", busy_end, 0);
        chk(nbusy == ((w > 0) ? (w + NCH - w/2) : 0), "R4 busy length", nbusy,
            (w > 0) ? (w + NCH - w/2) : 0);
    endtask

    task automatic t_reset();
        chk(copy_busy == 0 && fifo_wr == 0, "R4 reset idle", {copy_busy, fifo_wr}, 0);
        chk(overrun == 0 && acq_stop == 0, "R10 reset flags", {overrun, acq_stop}, 0);
    endtask

    task automatic t_basic();
        count(3, 5, 0, 7);
        user_in = 2'b10;
        fire(1, 0);
        user_m = 2; live_m = 1;
        check_copy("R1 R2 R5 R7 ext copy bank0", 0, 0);
    endtask

    task automatic t_accum();
        count(2, 0, 0, 0);
        user_in = 2'b01;
        fire(0, 0); live_m = 0;
        check_copy("R2 R7 sw copy bank1 keeps user", 1, 0);
        count(4, 1, 0, 0);
        fire(0, 0); live_m = 1;
        check_copy("R3 accumulate bank0", 0, 0);
    endtask

    task automatic t_mask();
        mask_in = 4'h5; mask_we = 1'b1; @(negedge clk); mask_we = 1'b0;
        count(1, 1, 1, 1);
        fire(0, 2); live_m = 0;
        check_copy("R6 skip mask 0x5", 1, 5);
        fire(0, 0); live_m = 1;
        check_copy("R6 staged mask applied later", 0, 0);
    endtask

    task automatic t_arm();
        next_arm = 1'b0;
        fire(0, 0);
        chk(ncap == 0 && nbusy == 0, "R11 sw ignored unarmed", ncap + nbusy, 0);
        fire(1, 0);
        chk(ncap == 0 && nbusy == 0, "R11 ext ignored unarmed", ncap + nbusy, 0);
        chk(overrun == 0, "R11 no overrun", overrun, 0);
        count(1, 0, 0, 0);
        next_arm = 1'b1;
        fire(0, 0); live_m = 0;
        check_copy("R11 bank unchanged after ignored", 1, 0);
    endtask

    task automatic t_overrun();
        fire(0, 1); live_m = 1;
        check_copy("R8 second request ignored", 0, 0);
        chk(overrun == 1, "R8 overrun set", overrun, 1);
    endtask

    task automatic t_full();
        fifo_full = 1'b1; @(negedge clk); fifo_full = 1'b0; @(negedge clk);
        chk(acq_stop == 1, "R9 stop sticky", acq_stop, 1);
        count(5, 5, 5, 5);
        fire(0, 0);
        chk(ncap == 0 && nbusy == 0, "R9 no copy while stopped", ncap + nbusy, 0);
    endtask

    task automatic t_clear();
        clear = 1'b1; #0.5;
        chk(fifo_flush == 1, "R10 flush", fifo_flush, 1);
        @(negedge clk); clear = 1'b0;
        chk(acq_stop == 0 && overrun == 0, "R10 flags cleared", {acq_stop, overrun}, 0);
        for (int b = 0; b < 2; b++) for (int i = 0; i < NCH; i++) mdl[b][i] = 0;
        live_m = 0; user_m = 0;
        count(0, 2, 0, 0);
        fire(0, 0); live_m = 1;
        check_copy("R10 R9 banks zeroed, count halted", 0, 0);
    endtask

    initial begin
        for (int b = 0; b < 2; b++) for (int i = 0; i < NCH; i++) mdl[b][i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        next_arm = 1'b1;
        t_basic();
        t_accum();
        t_mask();
        t_arm();
        t_overrun();
        t_full();
        t_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule